// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It looks at the register specifiers and control flags held in the four stage registers, plus the branch condition result computed in decode. From them it produces the operand bypass selects for the execute stage, a bypass select for the store data in the memory stage, and a bypass select for the register tested by a branch in decode. It also produces the hold, bubble, squash and next-PC controls. The datapath around it, including the multiplexers these selects steer, is outside the block.

Sources are read only in decode and results are written only in write-back, so read-after-write dependences are the only hazards handled. Most are resolved by forwarding. Two cases stall. The first is an instruction that needs, in execute, the result of the load just ahead of it. The second is a branch whose tested register is not yet available to decode. Branches are resolved in decode by an equal-zero or not-zero test and are predicted not taken. A taken branch replaces the one instruction fetched behind it with a no-op.

The outputs are combinational functions of the stage-register contents. The clock and reset inputs serve only the embedded property checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the EX/MEM entry writes a nonzero register that is not a load, and that register equals an execute-stage source, the select for that operand (A from ex_rs1, B from ex_rs2, decided independently) is 2'b10.
- R2: When the MEM/WB entry writes a nonzero register equal to an execute-stage source, and R1 does not apply to that operand, the select is 2'b01. An EX/MEM match takes priority over a MEM/WB match. An EX/MEM load is never selected in execute.
- R3: Register 0 never produces a forwarding select, a store-data bypass or a stall, whatever the write enables say.
- R4: A load in ID/EX whose destination is read by the decode instruction raises pc_hold, ifid_hold and idex_bubble. Here "read" means rs1 with id_use_rs1 set, or rs2 with id_use_rs2 set when the instruction is not a store. In a running pipeline this costs exactly one stall cycle.
- R5: A store in decode whose data register (rs2) is the destination of the load in ID/EX does not stall. When EX/MEM holds a store whose data register is written (nonzero) by the MEM/WB entry, mem_sd_fwd is 1.
- R6: A branch in decode stalls while its tested register (rs1, nonzero) is written by the ID/EX instruction, or by a load in EX/MEM.
- R7: For a non-stalled branch, id_br_fwd is 2'b10 when the tested register comes from a non-load EX/MEM entry. It is 2'b01 when it comes from MEM/WB and EX/MEM does not match. Otherwise it is 2'b00.
- R8: A non-stalled branch is taken when id_br_nez is 0 and id_zero is 1, or when id_br_nez is 1 and id_zero is 0. A taken branch sets pc_sel to 1 and ifid_flush to 1 in the same cycle. A stalled branch is never taken.
- R9: With no matching writer and no branch, every select is 2'b00, mem_sd_fwd is 0, and no hold, bubble, flush or branch-target select is raised. A five-instruction chain that depends on one ALU result runs with no stall, taking 2'b10, then 2'b01, then 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| id_rs1 | input | 5 | Decode source 1; also the branch-tested register |
| id_rs2 | input | 5 | Decode source 2; store data register for stores |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 |
| id_is_store | input | 1 | Decode instruction is a store |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_nez | input | 1 | 0: branch if zero, 1: branch if not zero |
| id_zero | input | 1 | Zero-test result on the forwarded tested register |
| ex_rs1 | input | 5 | ID/EX source 1 |
| ex_rs2 | input | 5 | ID/EX source 2 |
| ex_rd | input | 5 | ID/EX destination |
| ex_wr | input | 1 | ID/EX writes a register |
| ex_load | input | 1 | ID/EX is a load |
| mem_rd | input | 5 | EX/MEM destination |
| mem_wr | input | 1 | EX/MEM writes a register |
| mem_load | input | 1 | EX/MEM is a load |
| mem_store | input | 1 | EX/MEM is a store |
| mem_rs2 | input | 5 | EX/MEM store data register |
| wb_rd | input | 5 | MEM/WB destination |
| wb_wr | input | 1 | MEM/WB writes a register |
| ex_fwd_a | output | 2 | Operand A select: 00 register file, 01 MEM/WB, 10 EX/MEM |
| ex_fwd_b | output | 2 | Operand B select, same encoding |
| mem_sd_fwd | output | 1 | Store data taken from the MEM/WB result |
| id_br_fwd | output | 2 | Tested-register select in decode, same encoding |
| pc_hold | output | 1 | Hold the PC |
| ifid_hold | output | 1 | Hold IF/ID |
| idex_bubble | output | 1 | Zero the control fields entering ID/EX |
| ifid_flush | output | 1 | Replace the IF/ID entry with a no-op |
| pc_sel | output | 1 | 0: sequential PC, 1: branch target |

## Verification
The hardest situation to reach is a branch that sits behind a load of its own tested register. It must stall once while the load is in execute and once more while the load is in memory, and only then take the write-back value and resolve. The same holds for a branch directly behind an ALU writer, which stalls once and then takes the EX/MEM value in the cycle it squashes its successor. The stimulus reaches these cases two ways. Directed stage-register snapshots pin down each select in isolation. A behavioural model of the four stage registers then replays short programs, obeying the hold, bubble and flush outputs, so that stall counts and per-instruction selects come from real instruction flow.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned RA_W = 5;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_EXM = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        PC_SEQ = 1'b0,
        PC_BRT = 1'b1
    } pc_sel_e;

    typedef struct packed {
        logic            wr;
        logic            load;
        logic [RA_W-1:0] rd;
    } wr_tag_t;

    function automatic logic reg_hits(input logic wr, input logic [RA_W-1:0] rd,
                                      input logic [RA_W-1:0] rs);
        return wr && (rd != '0) && (rd == rs);
    endfunction

    function automatic logic tag_hits(input wr_tag_t t, input logic [RA_W-1:0] rs);
        return reg_hits(t.wr, t.rd, rs);
    endfunction

endpackage

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
    import hzd_pkg::*;
#(
    parameter int unsigned N_OPS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_OPS-1:0][RA_W-1:0] ex_src,
    input  wr_tag_t                    exm_tag,
    input  logic                       wb_wr,
    input  logic [RA_W-1:0]            wb_rd,
    input  logic                       mem_store,
    input  logic [RA_W-1:0]            mem_data_reg,
    output logic [N_OPS-1:0][1:0]      ex_sel,
    output logic                       sd_fwd
);

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        always_comb begin
            if (tag_hits(exm_tag, ex_src[i]) && !exm_tag.load) begin
                ex_sel[i] = FWD_EXM;
            end else if (reg_hits(wb_wr, wb_rd, ex_src[i])) begin
                ex_sel[i] = FWD_WB;
            end else begin
                ex_sel[i] = FWD_RF;
            end
        end

        AST_OP_NO_R0_FWD: assert property (@(posedge clk) disable iff (rst)
            (ex_sel[i] != FWD_RF) |-> (ex_src[i] != '0))
            else $error("operand bypass selected for register 0"); // R3
    end

    always_comb begin
        sd_fwd = mem_store && reg_hits(wb_wr, wb_rd, mem_data_reg);
    end

    AST_SD_NO_R0: assert property (@(posedge clk) disable iff (rst)
        sd_fwd |-> (mem_data_reg != '0))
        else $error("store data bypass for register 0"); // R3

endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit
    import hzd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RA_W-1:0] id_rs1,
    input  logic [RA_W-1:0] id_rs2,
    input  logic            id_use_rs1,
    input  logic            id_use_rs2,
    input  logic            id_is_store,
    input  logic            id_is_branch,
    input  wr_tag_t         ex_tag,
    input  wr_tag_t         mem_tag,
    output logic            load_use,
    output logic            br_wait,
    output logic            stall
);

    logic rs1_on_ex;
    logic rs2_on_ex;

    always_comb begin
        rs1_on_ex = tag_hits(ex_tag, id_rs1);
        rs2_on_ex = tag_hits(ex_tag, id_rs2);
        // store data (rs2 of a store) is repaired later in the memory stage
        load_use  = ex_tag.load &&
                    ((id_use_rs1 && rs1_on_ex) ||
                     (id_use_rs2 && !id_is_store && rs2_on_ex));
        br_wait   = id_is_branch &&
                    (rs1_on_ex || (mem_tag.load && tag_hits(mem_tag, id_rs1)));
        stall     = load_use || br_wait;
    end

    AST_LOAD_USE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load_use |=> !load_use)
        else $error("load-use stall lasted more than one cycle"); // R4

endmodule

// File: rtl/hzd_branch_unit.sv
module hzd_branch_unit
    import hzd_pkg::*;
(
    input  logic            id_is_branch,
    input  logic            id_br_nez,
    input  logic            id_zero,
    input  logic [RA_W-1:0] id_rs1,
    input  wr_tag_t         exm_tag,
    input  logic            wb_wr,
    input  logic [RA_W-1:0] wb_rd,
    input  logic            stall,
    output logic [1:0]      br_sel,
    output logic            taken
);

    logic cond_met;

    always_comb begin
        if (tag_hits(exm_tag, id_rs1) && !exm_tag.load) begin
            br_sel = FWD_EXM;
        end else if (reg_hits(wb_wr, wb_rd, id_rs1)) begin
            br_sel = FWD_WB;
        end else begin
            br_sel = FWD_RF;
        end
        cond_met = id_br_nez ? !id_zero : id_zero;
        taken    = id_is_branch && !stall && cond_met;
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hzd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RA_W-1:0] id_rs1,
    input  logic [RA_W-1:0] id_rs2,
    input  logic            id_use_rs1,
    input  logic            id_use_rs2,
    input  logic            id_is_store,
    input  logic            id_is_branch,
    input  logic            id_br_nez,
    input  logic            id_zero,
    input  logic [RA_W-1:0] ex_rs1,
    input  logic [RA_W-1:0] ex_rs2,
    input  logic [RA_W-1:0] ex_rd,
    input  logic            ex_wr,
    input  logic            ex_load,
    input  logic [RA_W-1:0] mem_rd,
    input  logic            mem_wr,
    input  logic            mem_load,
    input  logic            mem_store,
    input  logic [RA_W-1:0] mem_rs2,
    input  logic [RA_W-1:0] wb_rd,
    input  logic            wb_wr,
    output logic [1:0]      ex_fwd_a,
    output logic [1:0]      ex_fwd_b,
    output logic            mem_sd_fwd,
    output logic [1:0]      id_br_fwd,
    output logic            pc_hold,
    output logic            ifid_hold,
    output logic            idex_bubble,
    output logic            ifid_flush,
    output logic            pc_sel
);

    localparam int unsigned N_EX_OPS = 2;

    wr_tag_t                        ex_tag;
    wr_tag_t                        mem_tag;
    logic [N_EX_OPS-1:0][RA_W-1:0]  ex_src;
    logic [N_EX_OPS-1:0][1:0]       ex_sel;
    logic                           load_use;
    logic                           br_wait;
    logic                           stall;
    logic                           br_taken;

    always_comb begin
        ex_tag    = '{wr: ex_wr,  load: ex_load,  rd: ex_rd};
        mem_tag   = '{wr: mem_wr, load: mem_load, rd: mem_rd};
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    hzd_fwd_unit #(.N_OPS(N_EX_OPS)) u_fwd (
        .clk          (clk),
        .rst          (rst),
        .ex_src       (ex_src),
        .exm_tag      (mem_tag),
        .wb_wr        (wb_wr),
        .wb_rd        (wb_rd),
        .mem_store    (mem_store),
        .mem_data_reg (mem_rs2),
        .ex_sel       (ex_sel),
        .sd_fwd       (mem_sd_fwd)
    );

    hzd_stall_unit u_stall (
        .clk          (clk),
        .rst          (rst),
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_use_rs1   (id_use_rs1),
        .id_use_rs2   (id_use_rs2),
        .id_is_store  (id_is_store),
        .id_is_branch (id_is_branch),
        .ex_tag       (ex_tag),
        .mem_tag      (mem_tag),
        .load_use     (load_use),
        .br_wait      (br_wait),
        .stall        (stall)
    );

    hzd_branch_unit u_branch (
        .id_is_branch (id_is_branch),
        .id_br_nez    (id_br_nez),
        .id_zero      (id_zero),
        .id_rs1       (id_rs1),
        .exm_tag      (mem_tag),
        .wb_wr        (wb_wr),
        .wb_rd        (wb_rd),
        .stall        (stall),
        .br_sel       (id_br_fwd),
        .taken        (br_taken)
    );

    always_comb begin
        ex_fwd_a    = ex_sel[0];
        ex_fwd_b    = ex_sel[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
        ifid_flush  = br_taken;
        pc_sel      = br_taken ? PC_BRT : PC_SEQ;
    end

    AST_EXM_WINS_A: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_load && mem_rd != '0 && mem_rd == ex_rs1) |-> (ex_fwd_a == FWD_EXM))
        else $error("operand A missed EX/MEM bypass"); // R1

    AST_WB_FALLBACK_B: assert property (@(posedge clk) disable iff (rst)
        (wb_wr && wb_rd != '0 && wb_rd == ex_rs2 && !(mem_wr && mem_rd == ex_rs2))
        |-> (ex_fwd_b == FWD_WB))
        else $error("operand B missed MEM/WB bypass"); // R2

    AST_STORE_DATA_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (id_is_store && !id_is_branch && ex_load && id_rs2 == ex_rd && id_rs1 != ex_rd)
        |-> !pc_hold)
        else $error("load to store data stalled"); // R5

    AST_BR_WAIT_EX: assert property (@(posedge clk) disable iff (rst)
        (id_is_branch && ex_wr && id_rs1 != '0 && ex_rd == id_rs1) |-> (pc_hold && !ifid_flush))
        else $error("branch resolved before its operand"); // R6

    AST_BR_FWD_WB: assert property (@(posedge clk) disable iff (rst)
        (id_is_branch && !pc_hold && wb_wr && id_rs1 != '0 && wb_rd == id_rs1 &&
         !(mem_wr && mem_rd == id_rs1)) |-> (id_br_fwd == FWD_WB))
        else $error("branch operand missed MEM/WB bypass"); // R7

    AST_FLUSH_NOT_HELD: assert property (@(posedge clk) disable iff (rst)
        ifid_flush |-> (!pc_hold && pc_sel == PC_BRT))
        else $error("squash during stall or without target"); // R8

endmodule

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
    import hzd_pkg::*;

    typedef struct packed {
        logic [3:0]      tag;
        logic [RA_W-1:0] rd;
        logic [RA_W-1:0] rs1;
        logic [RA_W-1:0] rs2;
        logic u1, u2, wr, ld, st, br, nez, zero;
        logic [3:0]      tgt;
    } ins_t;

    typedef struct {
        logic [11:0] bits;
        string       req;
    } exp_t;

    localparam ins_t NOP = '{tag: 4'hF, default: '0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    ins_t s_id = NOP, s_ex = NOP, s_mem = NOP, s_wb = NOP;

    logic [1:0] ex_fwd_a, ex_fwd_b, id_br_fwd;
    logic mem_sd_fwd, pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_sel;

    pipe_hazard_ctrl dut (
        .clk (clk), .rst (rst),
        .id_rs1 (s_id.rs1), .id_rs2 (s_id.rs2),
        .id_use_rs1 (s_id.u1), .id_use_rs2 (s_id.u2),
        .id_is_store (s_id.st), .id_is_branch (s_id.br),
        .id_br_nez (s_id.nez), .id_zero (s_id.zero),
        .ex_rs1 (s_ex.rs1), .ex_rs2 (s_ex.rs2), .ex_rd (s_ex.rd),
        .ex_wr (s_ex.wr), .ex_load (s_ex.ld),
        .mem_rd (s_mem.rd), .mem_wr (s_mem.wr), .mem_load (s_mem.ld),
        .mem_store (s_mem.st), .mem_rs2 (s_mem.rs2),
        .wb_rd (s_wb.rd), .wb_wr (s_wb.wr),
        .ex_fwd_a (ex_fwd_a), .ex_fwd_b (ex_fwd_b), .mem_sd_fwd (mem_sd_fwd),
        .id_br_fwd (id_br_fwd), .pc_hold (pc_hold), .ifid_hold (ifid_hold),
        .idex_bubble (idex_bubble), .ifid_flush (ifid_flush), .pc_sel (pc_sel)
    );

    int checks = 0;
    int errors = 0;
    exp_t sbq[$];

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic ins_t alu(int t, int d, int a, int b);
        ins_t r = NOP;
        r.tag = 4'(t); r.rd = RA_W'(d); r.rs1 = RA_W'(a); r.rs2 = RA_W'(b);
        r.u1 = 1'b1; r.u2 = 1'b1; r.wr = 1'b1;
        return r;
    endfunction

    function automatic ins_t ld(int t, int d, int a);
        ins_t r = NOP;
        r.tag = 4'(t); r.rd = RA_W'(d); r.rs1 = RA_W'(a);
        r.u1 = 1'b1; r.wr = 1'b1; r.ld = 1'b1;
        return r;
    endfunction

    function automatic ins_t sw(int t, int a, int b);
        ins_t r = NOP;
        r.tag = 4'(t); r.rs1 = RA_W'(a); r.rs2 = RA_W'(b);
        r.u1 = 1'b1; r.u2 = 1'b1; r.st = 1'b1;
        return r;
    endfunction

    function automatic ins_t brz(int t, int a, logic nez, logic zero, int tgt);
        ins_t r = NOP;
        r.tag = 4'(t); r.rs1 = RA_W'(a); r.u1 = 1'b1; r.br = 1'b1;
        r.nez = nez; r.zero = zero; r.tgt = 4'(tgt);
        return r;
    endfunction

    // driver: one stage-register snapshot per cycle, expected outputs queued
    task automatic apply(input ins_t i_id, input ins_t i_ex, input ins_t i_mem,
                         input ins_t i_wb, input logic [1:0] fa, input logic [1:0] fb,
                         input logic [1:0] bf, input logic sd, input logic hold,
                         input logic flush, input logic psel, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        s_id = i_id; s_ex = i_ex; s_mem = i_mem; s_wb = i_wb;
        e.bits = {fa, fb, bf, sd, hold, hold, hold, flush, psel};
        e.req  = req;
        sbq.push_back(e);
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (sbq.size() != 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk({ex_fwd_a, ex_fwd_b, id_br_fwd, mem_sd_fwd, pc_hold, ifid_hold,
                 idex_bubble, ifid_flush, pc_sel} == e.bits, e.req, "outputs",
                int'({ex_fwd_a, ex_fwd_b, id_br_fwd, mem_sd_fwd, pc_hold, ifid_hold,
                      idex_bubble, ifid_flush, pc_sel}), int'(e.bits));
        end
    end

    // behavioural stage-register model for program replay
    ins_t       prog [16];
    logic [1:0] obs_fa [16];
    logic [1:0] obs_fb [16];
    logic       obs_sd [16];
    logic       obs_ex [16];
    logic [1:0] obs_bf;
    int         stalls, flushes;

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) begin
            prog[i] = NOP; obs_fa[i] = 2'b11; obs_fb[i] = 2'b11;
            obs_sd[i] = 1'b0; obs_ex[i] = 1'b0;
        end
        obs_bf = 2'b11; stalls = 0; flushes = 0;
    endtask

    task automatic run_prog(input int ncyc);
        int   pc;
        logic hold_s, flush_s;
        pc = 0;
        @(posedge clk);
        #1;
        s_id = NOP; s_ex = NOP; s_mem = NOP; s_wb = NOP;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (s_ex.tag != 4'hF) begin
                obs_fa[s_ex.tag] = ex_fwd_a; obs_fb[s_ex.tag] = ex_fwd_b;
                obs_ex[s_ex.tag] = 1'b1;
            end
            if (s_mem.tag != 4'hF) obs_sd[s_mem.tag] = mem_sd_fwd;
            if (s_id.br && !pc_hold) obs_bf = id_br_fwd;
            hold_s = pc_hold; flush_s = ifid_flush;
            if (hold_s) stalls++;
            if (flush_s) flushes++;
            @(posedge clk);
            #1;
            s_wb  = s_mem;
            s_mem = s_ex;
            if (hold_s) begin
                s_ex = NOP;
            end else begin
                s_ex = s_id;
                if (flush_s) begin
                    pc   = int'(s_id.tgt);
                    s_id = NOP;
                end else begin
                    s_id = (pc < 16) ? prog[pc] : NOP;
                    pc++;
                end
            end
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;

        // R9: idle stage registers give neutral outputs
        apply(NOP, NOP, NOP, NOP, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R9");
        // R1 and R2: A from EX/MEM, B from MEM/WB
        apply(NOP, alu(1, 9, 1, 2), alu(2, 1, 5, 5), alu(3, 2, 5, 5),
              2'b10, 2'b01, 2'b00, 0, 0, 0, 0, "R1");
        // R2: both stages match, EX/MEM wins
        apply(NOP, alu(1, 9, 3, 3), alu(2, 3, 5, 5), alu(3, 3, 5, 5),
              2'b10, 2'b10, 2'b00, 0, 0, 0, 0, "R2");
        // R2: EX/MEM load is not forwarded in execute, MEM/WB is used instead
        apply(NOP, alu(1, 9, 3, 4), ld(2, 3, 5), alu(3, 3, 5, 5),
              2'b01, 2'b00, 2'b00, 0, 0, 0, 0, "R2");
        // R3: register 0 writers never forwarded
        apply(NOP, alu(1, 9, 0, 0), alu(2, 0, 5, 5), alu(3, 0, 5, 5),
              2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R3");
        // R4: load-use on rs1
        apply(alu(2, 7, 5, 8), ld(1, 5, 2), NOP, NOP,
              2'b00, 2'b00, 2'b00, 0, 1, 0, 0, "R4");
        apply(NOP, NOP, NOP, NOP, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R9");
        // R5: load feeding store data only: no stall
        apply(sw(2, 6, 5), ld(1, 5, 2), NOP, NOP,
              2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R5");
        // R4: load feeding store base address: stall
        apply(sw(2, 5, 7), ld(1, 5, 2), NOP, NOP,
              2'b00, 2'b00, 2'b00, 0, 1, 0, 0, "R4");
        apply(NOP, NOP, NOP, NOP, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R9");
        // R5: store data bypass in memory stage
        apply(NOP, NOP, sw(2, 6, 9), alu(1, 9, 3, 3),
              2'b00, 2'b00, 2'b00, 1, 0, 0, 0, "R5");
        // R3: store data on r0 never bypassed; load to r0 never stalls
        apply(alu(3, 7, 0, 0), ld(4, 0, 2), sw(2, 6, 0), alu(1, 0, 3, 3),
              2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R3");
        // R6: branch waits on ALU writer in execute
        apply(brz(2, 4, 0, 1, 5), alu(1, 4, 2, 3), NOP, NOP,
              2'b00, 2'b00, 2'b00, 0, 1, 0, 0, "R6");
        // R6: branch waits on load in memory stage
        apply(brz(2, 4, 0, 1, 5), NOP, ld(1, 4, 2), NOP,
              2'b00, 2'b00, 2'b00, 0, 1, 0, 0, "R6");
        // R7 and R8: EX/MEM bypass into decode, branch-if-zero taken
        apply(brz(2, 4, 0, 1, 5), NOP, alu(1, 4, 2, 3), NOP,
              2'b00, 2'b00, 2'b10, 0, 0, 1, 1, "R7");
        // R7 and R8: MEM/WB bypass, branch-if-not-zero with zero set: not taken
        apply(brz(2, 4, 1, 1, 5), NOP, NOP, alu(1, 4, 2, 3),
              2'b00, 2'b00, 2'b01, 0, 0, 0, 0, "R7");
        // R8: branch-if-not-zero with zero clear: taken
        apply(brz(2, 6, 1, 0, 5), NOP, NOP, NOP,
              2'b00, 2'b00, 2'b00, 0, 0, 1, 1, "R8");
        // R8: branch-if-zero with zero clear: not taken
        apply(brz(2, 6, 0, 0, 5), NOP, NOP, NOP,
              2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R8");
        apply(NOP, NOP, NOP, NOP, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, "R9");
        @(negedge clk);
        @(negedge clk);

        // R9 / R1 / R2: dependency chain on r1
        clear_prog();
        prog[0] = alu(0, 1, 2, 3);
        prog[1] = alu(1, 4, 1, 3);
        prog[2] = alu(2, 6, 1, 7);
        prog[3] = alu(3, 8, 1, 9);
        prog[4] = alu(4, 10, 1, 11);
        run_prog(12);
        chk(obs_fa[1] == 2'b10, "R1", "chain sub A", obs_fa[1], 2);
        chk(obs_fa[2] == 2'b01, "R2", "chain and A", obs_fa[2], 1);
        chk(obs_fa[3] == 2'b00, "R9", "chain or A", obs_fa[3], 0);
        chk(obs_fa[4] == 2'b00, "R9", "chain xor A", obs_fa[4], 0);
        chk(stalls == 0, "R9", "chain stalls", stalls, 0);

        // R4: load-use sequence, exactly one bubble
        clear_prog();
        prog[0] = ld(0, 1, 2);
        prog[1] = alu(1, 4, 1, 6);
        prog[2] = alu(2, 6, 1, 7);
        prog[3] = alu(3, 8, 1, 9);
        run_prog(12);
        chk(stalls == 1, "R4", "load-use stalls", stalls, 1);
        chk(obs_fa[1] == 2'b01, "R4", "sub A after bubble", obs_fa[1], 1);
        chk(obs_fa[2] == 2'b00, "R4", "and A", obs_fa[2], 0);
        chk(obs_fa[3] == 2'b00, "R4", "or A", obs_fa[3], 0);

        // R5: load to store data without stall
        clear_prog();
        prog[0] = alu(0, 1, 2, 3);
        prog[1] = ld(1, 4, 1);
        prog[2] = sw(2, 1, 4);
        run_prog(10);
        chk(stalls == 0, "R5", "load-store stalls", stalls, 0);
        chk(obs_fa[1] == 2'b10, "R1", "lw base", obs_fa[1], 2);
        chk(obs_fa[2] == 2'b01, "R2", "sw base", obs_fa[2], 1);
        chk(obs_fb[2] == 2'b00, "R2", "sw data in EX", obs_fb[2], 0);
        chk(obs_sd[2] == 1'b1, "R5", "sw data in MEM", obs_sd[2], 1);

        // R6 / R7 / R8: branch behind its ALU writer, taken, successor squashed
        clear_prog();
        prog[0] = alu(0, 1, 2, 3);
        prog[1] = brz(1, 1, 0, 1, 5);
        prog[2] = alu(2, 12, 2, 2);
        prog[5] = alu(5, 10, 1, 11);
        run_prog(14);
        chk(stalls == 1, "R6", "branch stalls", stalls, 1);
        chk(obs_bf == 2'b10, "R7", "branch operand", obs_bf, 2);
        chk(flushes == 1, "R8", "squashes", flushes, 1);
        chk(obs_ex[2] == 1'b0, "R8", "squashed reached EX", obs_ex[2], 0);
        chk(obs_ex[5] == 1'b1, "R8", "target reached EX", obs_ex[5], 1);

        // R6: branch behind a load of its tested register stalls twice
        clear_prog();
        prog[0] = ld(0, 1, 2);
        prog[1] = brz(1, 1, 1, 1, 6);
        prog[2] = alu(2, 12, 2, 2);
        run_prog(12);
        chk(stalls == 2, "R6", "load-branch stalls", stalls, 2);
        chk(obs_bf == 2'b01, "R7", "load-branch operand", obs_bf, 1);
        chk(flushes == 0, "R8", "not-taken squashes", flushes, 0);
        chk(obs_ex[2] == 1'b1, "R8", "fall-through reached EX", obs_ex[2], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule